// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block records execution history for an on-chip debug unit. Every clock cycle it may receive one event from a main CPU and one from a coprocessor. Each event carries an access-valid flag, a change-of-flow flag, an address and a data word. An 8-bit control register sets four things: which source is traced, the capture mode, an address-window filter and where the trigger lands in the recorded session. Events that qualify are written into a circular buffer. Capture ends according to that trigger placement.

Software programs the control register while the unit is disarmed and then holds the arm input high. Once the trigger input fires, the unit records until the session is complete. It then raises a done flag and disarms itself. Dropping the arm input releases the unit so it can be armed again. The entry count and the buffer contents can be read at any time through a read port indexed by age. A secure input blocks all tracing and stops the source field from being enabled.

Top module: `trace_capture_ctrl`

## Requirements
- R1: Control bits [7:6] select the traced source: 00 none, 01 CPU, 10 coprocessor, 11 both. When both sources qualify in the same cycle, the CPU record is kept and the coprocessor record is dropped. Buffer word bit [AW+DW] is 0 for a CPU record and 1 for a coprocessor record. The address sits above the data in that word.
- R2: While secure_i is high, no record is stored and a register write cannot change bits [7:6].
- R3: Bits [7:6] change on a write only when the unit is neither armed nor secured. Bits [5:0] change only when it is disarmed. reg_rdata_o always shows the register.
- R4: Mode code 00 in bits [3:2] (normal) stores only valid events that have the change-of-flow flag set.
- R5: Mode code 01 (loop) stores valid change-of-flow events, except one whose address equals either of the last two stored addresses.
- R6: Mode code 10 (detail) stores every valid access. When both sources are selected it stores nothing. Mode code 11 stores nothing.
- R7: Bits [5:4] filter CPU addresses in detail mode: 00 all, 01 address >= WIN_LO, 10 address <= WIN_HI, 11 inside [WIN_LO, WIN_HI]. Coprocessor records are never filtered. With both sources selected the field acts as 00.
- R8: Align code 00 in bits [1:0] (begin) stores from the trigger cycle on and completes once DEPTH records have been stored.
- R9: Align codes 01 and 11 (end) store from arming on and overwrite the oldest record once the buffer is full. The session completes in the trigger cycle, after that cycle's record is stored.
- R10: Align code 10 (mid) stores from arming on and completes after DEPTH/2 records stored from the trigger cycle onward.
- R11: When a session completes, done_o rises and armed_o falls at the same edge. A low arm_i disarms the unit. A new session starts when arm_i is high, the unit is disarmed and no session has completed since arm_i was last low. Starting a session clears done_o and the buffer.
- R12: entries_o counts stored records and saturates at DEPTH. rd_idx_i = 0 returns the oldest valid record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secure_i | input | 1 | System secured; blocks tracing |
| arm_i | input | 1 | Arm request level |
| trig_i | input | 1 | Trigger event |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register contents |
| cpu_vld_i | input | 1 | CPU access valid |
| cpu_cof_i | input | 1 | CPU change-of-flow flag |
| cpu_addr_i | input | AW | CPU address |
| cpu_data_i | input | DW | CPU data |
| cop_vld_i | input | 1 | Coprocessor access valid |
| cop_cof_i | input | 1 | Coprocessor change-of-flow flag |
| cop_addr_i | input | AW | Coprocessor address |
| cop_data_i | input | DW | Coprocessor data |
| rd_idx_i | input | log2(DEPTH) | Readout index by age, 0 = oldest |
| rd_data_o | output | 1+AW+DW | Selected buffer record |
| entries_o | output | log2(DEPTH)+1 | Number of valid records |
| armed_o | output | 1 | Unit armed |
| done_o | output | 1 | Session complete |

## Verification
The bench sweeps all 256 control settings on an 8-entry buffer. Each setting runs with random events, with the trigger at a different point and with occasional secure pulses. The sharp cases are loop-mode repeats against the two-entry history, buffer wrap for end alignment, and the exact completion point for begin and mid alignment. A design that got these wrong would store repeated addresses, read back records in the wrong age order, or stop one entry early or late. The bench also targets the lock rules and the dual-source detail case. Getting those wrong would let a write land while armed or secured, or would fill the buffer when it must stay empty.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {SRC_OFF = 2'b00, SRC_CPU = 2'b01, SRC_COP = 2'b10, SRC_BOTH = 2'b11} trc_src_e;
  typedef enum logic [1:0] {MODE_NORMAL = 2'b00, MODE_LOOP = 2'b01, MODE_DETAIL = 2'b10, MODE_RSVD = 2'b11} trc_mode_e;
  typedef enum logic [1:0] {ALN_BEGIN = 2'b00, ALN_END = 2'b01, ALN_MID = 2'b10, ALN_END_ALT = 2'b11} trc_align_e;

  typedef struct packed {
    trc_src_e   src;
    logic [1:0] rng;
    trc_mode_e  mode;
    trc_align_e align;
  } trc_ctrl_t;

  // number of records stored from the trigger cycle onward before completion
  function automatic int unsigned post_limit(trc_align_e a, int unsigned depth);
    case (a)
      ALN_BEGIN: return depth;
      ALN_MID:   return depth / 2;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/trc_regs.sv
module trc_regs
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secure_i,
  input  logic       armed_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output trc_ctrl_t  ctrl_o
);
  logic [7:0] ctrl_q;
  logic       src_wr_ok;
  logic       low_wr_ok;

  assign src_wr_ok = we_i && !armed_i && !secure_i;
  assign low_wr_ok = we_i && !armed_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (src_wr_ok) ctrl_q[7:6] <= wdata_i[7:6];
      if (low_wr_ok) ctrl_q[5:0] <= wdata_i[5:0];
    end
  end

  assign rdata_o = ctrl_q;
  assign ctrl_o  = trc_ctrl_t'(ctrl_q);

  p_src_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (armed_i || secure_i)) |=> $stable(ctrl_q[7:6]));
  p_low_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && armed_i) |=> $stable(ctrl_q[5:0]));
endmodule

// File: rtl/trc_qualify.sv
module trc_qualify
  import trc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] WIN_LO = '0,
  parameter logic [AW-1:0] WIN_HI = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  trc_ctrl_t     ctrl_i,
  input  logic          secure_i,
  input  logic          cpu_vld_i,
  input  logic          cpu_cof_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_data_i,
  input  logic          cop_vld_i,
  input  logic          cop_cof_i,
  input  logic [AW-1:0] cop_addr_i,
  input  logic [DW-1:0] cop_data_i,
  input  logic [AW-1:0] hist0_i,
  input  logic [AW-1:0] hist1_i,
  input  logic [1:0]    hist_vld_i,
  output logic          cand_vld_o,
  output logic          cand_src_o,
  output logic [AW-1:0] cand_addr_o,
  output logic [DW-1:0] cand_data_o
);
  function automatic logic in_window(logic [1:0] rng, logic [AW-1:0] a);
    case (rng)
      2'b01:   return a >= WIN_LO;
      2'b10:   return a <= WIN_HI;
      2'b11:   return (a >= WIN_LO) && (a <= WIN_HI);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic repeat_hit(logic [AW-1:0] a);
    return (hist_vld_i[0] && a == hist0_i) || (hist_vld_i[1] && a == hist1_i);
  endfunction

  logic [1:0] eff_src;
  logic       both;
  logic [1:0] rng_eff;
  logic       cpu_take;
  logic       cop_take;

  assign eff_src = secure_i ? 2'b00 : ctrl_i.src;
  assign both    = (eff_src == 2'b11);
  assign rng_eff = both ? 2'b00 : ctrl_i.rng;

  always_comb begin
    cpu_take = 1'b0;
    cop_take = 1'b0;
    case (ctrl_i.mode)
      MODE_NORMAL: begin
        cpu_take = cpu_cof_i;
        cop_take = cop_cof_i;
      end
      MODE_LOOP: begin
        cpu_take = cpu_cof_i && !repeat_hit(cpu_addr_i);
        cop_take = cop_cof_i && !repeat_hit(cop_addr_i);
      end
      MODE_DETAIL: begin
        cpu_take = !both && in_window(rng_eff, cpu_addr_i);
        cop_take = !both;
      end
      default: ;
    endcase
    cpu_take = cpu_take && eff_src[0] && cpu_vld_i;
    cop_take = cop_take && eff_src[1] && cop_vld_i;
  end

  assign cand_vld_o  = cpu_take || cop_take;
  assign cand_src_o  = !cpu_take;
  assign cand_addr_o = cpu_take ? cpu_addr_i : cop_addr_i;
  assign cand_data_o = cpu_take ? cpu_data_i : cop_data_i;

  p_secure_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    secure_i |-> !cand_vld_o);
  p_both_detail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.src == SRC_BOTH && ctrl_i.mode == MODE_DETAIL) |-> !cand_vld_o);
endmodule

// File: rtl/trc_store.sv
module trc_store
  import trc_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1,
  localparam int unsigned RW   = 1 + AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          trig_i,
  input  trc_align_e    align_i,
  input  logic          cand_vld_i,
  input  logic          cand_src_i,
  input  logic [AW-1:0] cand_addr_i,
  input  logic [DW-1:0] cand_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [RW-1:0] rd_data_o,
  output logic [CW-1:0] entries_o,
  output logic          armed_o,
  output logic          done_o,
  output logic [AW-1:0] hist0_o,
  output logic [AW-1:0] hist1_o,
  output logic [1:0]    hist_vld_o
);
  function automatic logic [PW-1:0] age_to_slot(logic [PW-1:0] wp, logic [CW-1:0] cnt, logic [PW-1:0] idx);
    return wp - cnt[PW-1:0] + idx;
  endfunction

  logic [RW-1:0] mem [DEPTH];
  logic          armed_q, done_q, spent_q, tseen_q;
  logic [CW-1:0] cnt_q, post_q, post_nxt, limit;
  logic [PW-1:0] wptr_q;
  logic [AW-1:0] h0_q, h1_q;
  logic [1:0]    hv_q;

  // named internal events
  logic start, live, trig_now, open, we, finish;

  assign start    = arm_i && !armed_q && !spent_q;
  assign live     = armed_q && arm_i;
  assign trig_now = live && (trig_i || tseen_q);
  assign open     = (align_i == ALN_BEGIN) ? trig_now : 1'b1;
  assign we       = live && cand_vld_i && open;
  assign post_nxt = post_q + {{(CW-1){1'b0}}, (trig_now && we)};
  assign limit    = CW'(post_limit(align_i, DEPTH));
  assign finish   = trig_now && (post_nxt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; done_q <= 1'b0; spent_q <= 1'b0; tseen_q <= 1'b0;
      cnt_q <= '0; post_q <= '0; wptr_q <= '0;
      h0_q <= '0; h1_q <= '0; hv_q <= '0;
    end else if (!arm_i) begin
      armed_q <= 1'b0;
      spent_q <= 1'b0;
    end else if (start) begin
      armed_q <= 1'b1; done_q <= 1'b0; tseen_q <= 1'b0;
      cnt_q <= '0; post_q <= '0; wptr_q <= '0; hv_q <= '0;
    end else if (armed_q) begin
      if (we) begin
        wptr_q <= wptr_q + 1'b1;
        cnt_q  <= (cnt_q == CW'(DEPTH)) ? cnt_q : cnt_q + 1'b1;
        h1_q   <= h0_q;
        h0_q   <= cand_addr_i;
        hv_q   <= {hv_q[0], 1'b1};
      end
      post_q  <= post_nxt;
      tseen_q <= trig_now;
      if (finish) begin
        armed_q <= 1'b0;
        done_q  <= 1'b1;
        spent_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wptr_q] <= {cand_src_i, cand_addr_i, cand_data_i};
  end

  assign rd_data_o  = mem[age_to_slot(wptr_q, cnt_q, rd_idx_i)];
  assign entries_o  = cnt_q;
  assign armed_o    = armed_q;
  assign done_o     = done_q;
  assign hist0_o    = h0_q;
  assign hist1_o    = h1_q;
  assign hist_vld_o = hv_q;

  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !armed_q);
  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !we);
  p_begin_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && align_i == ALN_BEGIN) |=> (cnt_q == CW'(DEPTH)));
  p_end_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && trig_i && align_i == ALN_END) |=> (!armed_q && done_q));
  p_mid_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && align_i == ALN_MID) |=> (post_q == CW'(DEPTH / 2)));
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import trc_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64,
  parameter logic [AW-1:0] WIN_LO = 16'h4000,
  parameter logic [AW-1:0] WIN_HI = 16'h7FFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     secure_i,
  input  logic                     arm_i,
  input  logic                     trig_i,
  input  logic                     reg_we_i,
  input  logic [7:0]               reg_wdata_i,
  output logic [7:0]               reg_rdata_o,
  input  logic                     cpu_vld_i,
  input  logic                     cpu_cof_i,
  input  logic [AW-1:0]            cpu_addr_i,
  input  logic [DW-1:0]            cpu_data_i,
  input  logic                     cop_vld_i,
  input  logic                     cop_cof_i,
  input  logic [AW-1:0]            cop_addr_i,
  input  logic [DW-1:0]            cop_data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
  output logic [AW+DW:0]           rd_data_o,
  output logic [$clog2(DEPTH):0]   entries_o,
  output logic                     armed_o,
  output logic                     done_o
);
  trc_ctrl_t     ctrl;
  logic          cand_vld, cand_src;
  logic [AW-1:0] cand_addr, hist0, hist1;
  logic [DW-1:0] cand_data;
  logic [1:0]    hist_vld;

  trc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .secure_i(secure_i), .armed_i(armed_o),
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .ctrl_o(ctrl)
  );

  trc_qualify #(.AW(AW), .DW(DW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_qual (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .secure_i(secure_i),
    .cpu_vld_i(cpu_vld_i), .cpu_cof_i(cpu_cof_i), .cpu_addr_i(cpu_addr_i), .cpu_data_i(cpu_data_i),
    .cop_vld_i(cop_vld_i), .cop_cof_i(cop_cof_i), .cop_addr_i(cop_addr_i), .cop_data_i(cop_data_i),
    .hist0_i(hist0), .hist1_i(hist1), .hist_vld_i(hist_vld),
    .cand_vld_o(cand_vld), .cand_src_o(cand_src), .cand_addr_o(cand_addr), .cand_data_o(cand_data)
  );

  trc_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_i), .align_i(ctrl.align),
    .cand_vld_i(cand_vld), .cand_src_i(cand_src), .cand_addr_i(cand_addr), .cand_data_i(cand_data),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .entries_o(entries_o),
    .armed_o(armed_o), .done_o(done_o),
    .hist0_o(hist0), .hist1_o(hist1), .hist_vld_o(hist_vld)
  );
endmodule

// File: tb/tb_trace_capture_ctrl.sv
`timescale 1ns/1ps
module tb_trace_capture_ctrl;
  localparam int AW = 8, DW = 8, DEPTH = 8;
  localparam logic [7:0] LO = 8'h40, HI = 8'h7F;

  logic clk = 0, rst_n = 0;
  logic secure_i = 0, arm_i = 0, trig_i = 0, reg_we_i = 0;
  logic [7:0] reg_wdata_i = 0, reg_rdata_o;
  logic cpu_vld_i = 0, cpu_cof_i = 0, cop_vld_i = 0, cop_cof_i = 0;
  logic [7:0] cpu_addr_i = 0, cpu_data_i = 0, cop_addr_i = 0, cop_data_i = 0;
  logic [2:0] rd_idx_i = 0;
  logic [16:0] rd_data_o;
  logic [3:0] entries_o;
  logic armed_o, done_o;

  always #2.5 clk = ~clk;

  trace_capture_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .WIN_LO(LO), .WIN_HI(HI)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  string tag = "R11";

  // reference model state
  logic [7:0] m_ctrl = 0;
  bit m_armed = 0, m_done = 0, m_spent = 0, m_tseen = 0;
  int m_post = 0;
  logic [16:0] m_q[$];
  logic [7:0] m_h0 = 0, m_h1 = 0;
  bit [1:0] m_hv = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit win_ok(logic [1:0] r, logic [7:0] a);
    case (r)
      2'd0: return 1;
      2'd1: return a >= LO;
      2'd2: return a <= HI;
      default: return a >= LO && a <= HI;
    endcase
  endfunction

  function automatic bit seen(logic [7:0] a);
    return (m_hv[0] && a == m_h0) || (m_hv[1] && a == m_h1);
  endfunction

  task automatic model_edge();
    logic [7:0] c = m_ctrl;
    bit was_armed = m_armed;
    logic [1:0] es;
    bit cpu_ok, cop_ok, tn, wr;
    int lim;
    es = secure_i ? 2'b00 : c[7:6];
    if (!arm_i) begin
      m_armed = 0; m_spent = 0;
    end else if (!m_armed && !m_spent) begin
      m_armed = 1; m_done = 0; m_tseen = 0; m_post = 0; m_hv = 0;
      m_q.delete();
    end else if (m_armed) begin
      case (c[3:2])
        2'd0: begin cpu_ok = cpu_cof_i; cop_ok = cop_cof_i; end
        2'd1: begin cpu_ok = cpu_cof_i && !seen(cpu_addr_i); cop_ok = cop_cof_i && !seen(cop_addr_i); end
        2'd2: begin cpu_ok = (es != 3) && win_ok((es == 3) ? 2'd0 : c[5:4], cpu_addr_i); cop_ok = (es != 3); end
        default: begin cpu_ok = 0; cop_ok = 0; end
      endcase
      cpu_ok = cpu_ok && es[0] && cpu_vld_i;
      cop_ok = cop_ok && es[1] && cop_vld_i;
      tn = trig_i || m_tseen;
      wr = (cpu_ok || cop_ok) && ((c[1:0] == 2'd0) ? tn : 1'b1);
      if (wr) begin
        m_q.push_back(cpu_ok ? {1'b0, cpu_addr_i, cpu_data_i} : {1'b1, cop_addr_i, cop_data_i});
        if (m_q.size() > DEPTH) void'(m_q.pop_front());
        m_h1 = m_h0; m_h0 = cpu_ok ? cpu_addr_i : cop_addr_i; m_hv = {m_hv[0], 1'b1};
      end
      if (tn && wr) m_post++;
      lim = (c[1:0] == 2'd0) ? DEPTH : (c[1:0] == 2'd2) ? DEPTH / 2 : 0;
      if (tn && m_post >= lim) begin m_armed = 0; m_done = 1; m_spent = 1; end
      m_tseen = tn;
    end
    if (reg_we_i) begin
      if (!was_armed && !secure_i) m_ctrl[7:6] = reg_wdata_i[7:6];
      if (!was_armed) m_ctrl[5:0] = reg_wdata_i[5:0];
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " R11 armed"}, armed_o, m_armed);
    chk({tag, " R11 done"}, done_o, m_done);
    chk({tag, " R12 entries"}, entries_o, m_q.size());
  endtask

  task automatic idle();
    cpu_vld_i = 0; cop_vld_i = 0; trig_i = 0; reg_we_i = 0;
  endtask

  task automatic dump();
    for (int i = 0; i < m_q.size(); i++) begin
      idle(); rd_idx_i = i[2:0];
      step();
      chk({tag, " R12 R1 record"}, rd_data_o, m_q[i]);
    end
  endtask

  function automatic logic [7:0] pick(int k);
    case (k % 8)
      0: return 8'h10; 1: return 8'h20; 2: return 8'h3F; 3: return 8'h40;
      4: return 8'h55; 5: return 8'h7F; 6: return 8'h80; default: return 8'h9A;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R11 reset armed", armed_o, 0);
    chk("R11 reset done", done_o, 0);
    chk("R12 reset entries", entries_o, 0);
    chk("R3 reset reg", reg_rdata_o, 0);

    // lock rules
    tag = "R3";
    reg_we_i = 1; reg_wdata_i = 8'h5A; step(); idle();
    chk("R3 write disarmed", reg_rdata_o, 8'h5A);
    arm_i = 1; step();
    chk("R11 armed after arm", armed_o, 1);
    reg_we_i = 1; reg_wdata_i = 8'hE4; step(); idle();
    chk("R3 write while armed ignored", reg_rdata_o, 8'h5A);
    arm_i = 0; step();
    tag = "R2";
    secure_i = 1; reg_we_i = 1; reg_wdata_i = 8'hC3; step(); idle();
    chk("R2 R3 secure blocks source bits", reg_rdata_o, 8'h43);
    secure_i = 0;

    // sweep all control settings
    for (int cfg = 0; cfg < 256; cfg++) begin
      string mt, at;
      int tpos;
      case (cfg[3:2]) 2'd0: mt = "R4"; 2'd1: mt = "R5"; default: mt = "R6 R7"; endcase
      case (cfg[1:0]) 2'd0: at = "R8"; 2'd2: at = "R10"; default: at = "R9"; endcase
      tag = {mt, " ", at, " R1"};
      idle(); arm_i = 0; step();
      reg_we_i = 1; reg_wdata_i = cfg[7:0]; step(); idle();
      chk({tag, " R3 cfg write"}, reg_rdata_o, cfg[7:0]);
      arm_i = 1;
      tpos = 4 + (cfg * 7) % 17;
      for (int c = 0; c < 32; c++) begin
        cpu_vld_i = ($urandom % 4) != 0; cpu_cof_i = $urandom % 2;
        cop_vld_i = ($urandom % 4) != 0; cop_cof_i = $urandom % 2;
        cpu_addr_i = pick($urandom); cop_addr_i = pick($urandom);
        cpu_data_i = $urandom; cop_data_i = $urandom;
        trig_i = (c == tpos);
        secure_i = (cfg % 5 == 0) ? (($urandom % 4) == 0) : 1'b0;
        reg_we_i = (c == 10); reg_wdata_i = $urandom;
        step();
      end
      idle(); secure_i = 0; step();
      chk({tag, " R3 reg held"}, reg_rdata_o, m_ctrl);
      dump();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule